// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive half of an I2C-compatible slave. It samples SCL and SDA on the system clock, detects start and stop conditions, and checks the first byte after each start against a programmed 7-bit own address. When that byte is a write to this slave, it acknowledges and then collects data bytes. Each byte, the address byte included, is handed to the host through a one-entry receive register with a data-ready flag.

The host side is a small register-style port. It has an enable, a bit-order select, an acknowledge-level bit, the ready flag with its byte, and a one-cycle read strobe. If the host has not taken the previous byte when a new one completes, the engine pulls SCL low until the host reads, and only then loads the new byte and answers it. The acknowledge level for a frame is frozen when the frame's first bit arrives. A change made later only takes effect from the following frame.

Both bus outputs are open-drain controls. A 1 pulls the line low and a 0 releases it. The engine has no baud generator because the master supplies the clock.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, both line pull-downs are released, rx_ready is 0 and rx_data is 0.
- R2: After a start, an address byte whose upper seven bits equal own_addr and whose last bit is 0 (write) is acknowledged: SDA is pulled low through the 9th SCL high phase when ack_level is 0. rx_ready then rises with rx_data holding the raw address byte {own_addr, 1'b0}, to be discarded by a dummy read. SDA is released once the 9th clock falls.
- R3: An address byte that does not match, or that matches with the last bit 1 (read), gets no acknowledge and does not set rx_ready. The data bytes that follow are also ignored until the next start.
- R4: With lsb_first = 0, a data byte is assembled so that the first bit on the wire lands in rx_data[7].
- R5: With lsb_first = 1, a data byte is assembled so that the first bit on the wire lands in rx_data[0]. The address byte is always assembled first-bit-in-bit-7.
- R6: A one-cycle pulse on rd_strobe clears rx_ready in the next cycle, unless a new byte is loaded in that same cycle.
- R7: If SCL falls after the 8th bit of an accepted frame while rx_ready is 1, SCL is held low and rx_data keeps the old byte. The first cycle after a read clears the flag, the new byte is loaded, rx_ready is set again and SCL is released.
- R8: The acknowledge level of a frame is ack_level as sampled at that frame's first SCL rise. ack_level = 1 leaves SDA released on the 9th clock (no acknowledge). A change made after that point, including during a stretch before the read, applies from the next frame.
- R9: A stop condition returns the engine to address wait. Bytes clocked after it without a new start are neither acknowledged nor reported.
- R10: Clearing enable releases both lines in the next cycle and returns the engine to address wait.
- R11: A repeated start, issued without a stop, restarts address comparison on the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; 0 forces address wait and releases the lines |
| lsb_first | input | 1 | 1 = data bytes assembled least significant bit first |
| ack_level | input | 1 | Level answered on the 9th clock; 0 = acknowledge |
| own_addr | input | 7 | Slave address compared against the first byte after a start |
| rd_strobe | input | 1 | One-cycle host read of rx_data; clears rx_ready |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 = pull SDA low (acknowledge) |
| rx_ready | output | 1 | Received byte waiting in rx_data |
| rx_data | output | 8 | Last received byte (address byte or data) |

## Verification
The bench leaves a byte unread so that the next one must stretch. It checks that SCL stays low over many cycles, that the read returns the old byte, and that the new byte appears only afterwards. A design that loaded early would lose data, and one that never released would hang the master. During that stretch the bench flips ack_level before the read. It expects the stalled frame to keep its frozen answer and the next frame to take the new one, which catches an engine that acknowledges from the live bit. Bit order is tested with a byte that is not a palindrome. Mismatched addresses, read-direction addresses, bytes clocked after a stop and a repeated start all check that address decoding is tied to the first frame after a start. Disabling the engine mid-stretch shows whether the engine can keep the bus stuck low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT   = 3'd1,
    ST_STRETCH = 3'd2,
    ST_ACK_LO  = 3'd3,
    ST_ACK_HI  = 3'd4
  } rx_state_t;

  // Add one received bit to a partly assembled byte.
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                 input logic              bit_v,
                                                 input logic              lsb_first);
    if (lsb_first) return {bit_v, cur[BYTE_W-1:1]};
    else           return {cur[BYTE_W-2:0], bit_v};
  endfunction

  // The address byte hits when the upper bits equal own address and the direction bit is write.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                    input logic [ADDR_W-1:0] own);
    return (frame[BYTE_W-1:1] == own) && (frame[0] == 1'b0);
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '1;
        last <= 1'b1;
      end else begin
        pipe <= {pipe[STAGES-2:0], raw[g]};
        last <= pipe[STAGES-1];
      end
    end

    assign level[g] = pipe[STAGES-1];
    assign rise[g]  = pipe[STAGES-1] & ~last;
    assign fall[g]  = ~pipe[STAGES-1] & last;
  end

endmodule

// File: rtl/i2cs_rx_buffer.sv
module i2cs_rx_buffer
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              rd_strobe,
  output logic              full,
  output logic [BYTE_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_byte;
    end else if (rd_strobe) begin
      full <= 1'b0;
    end
  end

  // R7: a byte is never written over one the host has not read
  assert_load_only_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full);

  // R6: a read without a simultaneous load empties the register
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !load) |=> !full);

  // R2: the flag only rises because a byte was delivered
  assert_flag_from_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(load));

endmodule

// File: rtl/i2cs_frame_fsm.sv
module i2cs_frame_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              lsb_first,
  input  logic              ack_level,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_bit,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              buf_full,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic              scl_hold,
  output logic              sda_hold
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  rx_state_t         st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_addr;
  logic              ack_cur;

  // Named internal events
  logic live;
  logic frame_end;
  logic accept;
  logic stretch_done;

  assign live         = enable & ~stop_evt & ~start_evt;
  assign frame_end    = live && (st == ST_SHIFT) && scl_fall && (bitcnt == LAST_BIT);
  assign accept       = frame_end && (!is_addr || addr_hit(shreg, own_addr));
  assign stretch_done = live && (st == ST_STRETCH) && !buf_full;

  assign load      = (accept && !buf_full) || stretch_done;
  assign load_byte = shreg;
  assign scl_hold  = (st == ST_STRETCH);
  assign sda_hold  = ((st == ST_STRETCH) || (st == ST_ACK_LO) || (st == ST_ACK_HI)) && !ack_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      is_addr <= 1'b0;
      ack_cur <= 1'b0;
    end else if (!enable || stop_evt) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
    end else if (start_evt) begin
      st      <= ST_SHIFT;
      bitcnt  <= '0;
      is_addr <= 1'b1;
    end else begin
      unique case (st)
        ST_SHIFT: begin
          if (scl_rise && bitcnt != LAST_BIT) begin
            shreg  <= shift_in(shreg, sda_bit, lsb_first & ~is_addr);
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == '0) ack_cur <= ack_level;
          end else if (frame_end) begin
            bitcnt <= '0;
            if (!accept)       st <= ST_IDLE;
            else if (buf_full) st <= ST_STRETCH;
            else               st <= ST_ACK_LO;
          end
        end
        ST_STRETCH: if (!buf_full) st <= ST_ACK_LO;
        ST_ACK_LO:  if (scl_rise)  st <= ST_ACK_HI;
        ST_ACK_HI: begin
          if (scl_fall) begin
            st      <= ST_SHIFT;
            is_addr <= 1'b0;
            bitcnt  <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: a stretch only starts while an unread byte is waiting
  assert_stretch_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> buf_full);

  // R7: once the host has read, SCL is let go on the next cycle
  assert_stretch_ends_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !buf_full && enable) |=> !scl_hold);

  // R10: disabling the engine frees both lines
  assert_disable_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_hold && !sda_hold));

  // R8: the acknowledge level cannot change while it is on the bus
  assert_ack_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ACK_HI) && $past(st == ST_ACK_HI)) |-> $stable(sda_hold));

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              lsb_first,
  input  logic              ack_level,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rd_strobe,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data
);

  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [1:0] lvl, rise, fall;
  logic       start_evt, stop_evt;
  logic       load;
  logic [BYTE_W-1:0] load_byte;
  logic       scl_hold, sda_hold;

  i2cs_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({sda_i, scl_i}),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  assign start_evt = fall[IDX_SDA] & lvl[IDX_SCL];
  assign stop_evt  = rise[IDX_SDA] & lvl[IDX_SCL];

  i2cs_frame_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .lsb_first (lsb_first),
    .ack_level (ack_level),
    .own_addr  (own_addr),
    .scl_rise  (rise[IDX_SCL]),
    .scl_fall  (fall[IDX_SCL]),
    .sda_bit   (lvl[IDX_SDA]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .buf_full  (rx_ready),
    .load      (load),
    .load_byte (load_byte),
    .scl_hold  (scl_hold),
    .sda_hold  (sda_hold)
  );

  i2cs_rx_buffer u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (load_byte),
    .rd_strobe (rd_strobe),
    .full      (rx_ready),
    .data      (rx_data)
  );

  assign scl_drive_low = scl_hold;
  assign sda_drive_low = sda_hold;

  // R10: nothing is delivered while the engine is off
  assert_no_load_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> enable);

endmodule

// File: tb/i2c_slave_rx_bench.sv
module i2c_slave_rx_bench;

  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, lsb_first = 1'b0, ack_level = 1'b0, rd_strobe = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_drive_low, sda_drive_low, rx_ready;
  logic [7:0] rx_data;
  logic scl_line, sda_line;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  assign scl_line = scl_m & ~scl_drive_low;
  assign sda_line = sda_m & ~sda_drive_low;

  always #10 clk = ~clk;

  i2c_slave_rx u_i2c_slave_rx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .lsb_first(lsb_first),
    .ack_level(ack_level), .own_addr(OWN), .rd_strobe(rd_strobe),
    .scl_i(scl_line), .sda_i(sda_line), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic clock_pulse();
    wait_clk(Q);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(Q);
  endtask

  // Sends a byte first bit = b[7]; returns 1 if the slave acknowledged.
  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      clock_pulse();
      scl_m = 1'b0;
      wait_clk(Q);
    end
    sda_m = 1'b1;
    wait_clk(Q);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(Q / 2);
    acked = !sda_line;
    wait_clk(Q / 2);
    scl_m = 1'b0;
    wait_clk(Q);
  endtask

  task automatic host_read(output logic [7:0] got);
    @(negedge clk);
    got = rx_data;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_stretch();
    for (int i = 0; i < 3000 && !scl_drive_low; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7 - i] = v[i];
    return r;
  endfunction

  task automatic t_reset();
    check(!scl_drive_low && !sda_drive_low, "R1 lines released", {scl_drive_low, sda_drive_low}, 0);
    check(!rx_ready, "R1 ready clear", rx_ready, 0);
    check(rx_data == 8'h00, "R1 data clear", rx_data, 0);
  endtask

  task automatic t_addr_and_msb();
    bit a; logic [7:0] got;
    lsb_first = 1'b0; ack_level = 1'b0;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    check(a, "R2 address acknowledged", a, 1);
    check(!sda_drive_low, "R2 SDA released after 9th", sda_drive_low, 0);
    check(rx_ready, "R2 ready on address", rx_ready, 1);
    host_read(got);
    check(got == {OWN, 1'b0}, "R2 dummy byte", got, {OWN, 1'b0});
    check(!rx_ready, "R6 read clears ready", rx_ready, 0);
    send_byte(8'hA1, a);
    check(a && rx_ready, "R4 data acknowledged", {a, rx_ready}, 3);
    host_read(got);
    check(got == 8'hA1, "R4 msb-first byte", got, 8'hA1);
    bus_stop();
  endtask

  task automatic t_lsb();
    bit a; logic [7:0] got;
    lsb_first = 1'b1;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    host_read(got);
    check(got == {OWN, 1'b0}, "R5 address not reversed", got, {OWN, 1'b0});
    send_byte(8'hA1, a);
    host_read(got);
    check(got == rev8(8'hA1), "R5 lsb-first byte", got, rev8(8'hA1));
    bus_stop();
    lsb_first = 1'b0;
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    send_byte({7'h33, 1'b0}, a);
    check(!a && !rx_ready, "R3 wrong address ignored", {a, rx_ready}, 0);
    send_byte(8'h00, a);
    check(!a && !rx_ready, "R3 following data ignored", {a, rx_ready}, 0);
    bus_stop();
    bus_start();
    send_byte({OWN, 1'b1}, a);
    check(!a && !rx_ready, "R3 read direction refused", {a, rx_ready}, 0);
    bus_stop();
  endtask

  task automatic t_stretch_ack();
    bit a, a2; logic [7:0] got, old;
    ack_level = 1'b0;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    host_read(got);
    send_byte(8'h11, a);
    check(a && rx_ready, "R7 first byte waiting", {a, rx_ready}, 3);
    fork
      send_byte(8'h22, a2);
      begin
        wait_stretch();
        check(scl_drive_low, "R7 stretch begins", scl_drive_low, 1);
        wait_clk(60);
        check(scl_drive_low && rx_data == 8'h11, "R7 held and old byte kept", rx_data, 8'h11);
        ack_level = 1'b1;
        host_read(old);
        check(old == 8'h11, "R7 read returns old byte", old, 8'h11);
      end
    join
    check(!scl_drive_low, "R7 SCL released", scl_drive_low, 0);
    check(a2, "R8 stalled frame keeps frozen ack", a2, 1);
    check(rx_ready && rx_data == 8'h22, "R7 new byte loaded", rx_data, 8'h22);
    host_read(got);
    send_byte(8'h33, a);
    check(!a, "R8 next frame takes new level", a, 0);
    check(rx_ready && rx_data == 8'h33, "R8 byte still delivered", rx_data, 8'h33);
    host_read(got);
    bus_stop();
    ack_level = 1'b0;
  endtask

  task automatic t_after_stop();
    bit a; logic [7:0] got;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    host_read(got);
    bus_stop();
    scl_m = 1'b0; wait_clk(Q);
    send_byte(8'h44, a);
    check(!a && !rx_ready, "R9 bytes after stop ignored", {a, rx_ready}, 0);
    bus_stop();
  endtask

  task automatic t_rstart();
    bit a; logic [7:0] got;
    bus_start();
    send_byte({7'h22, 1'b0}, a);
    check(!a, "R11 first address refused", a, 0);
    bus_start();
    send_byte({OWN, 1'b0}, a);
    check(a && rx_ready, "R11 repeated start matches", {a, rx_ready}, 3);
    host_read(got);
    check(got == {OWN, 1'b0}, "R11 address byte", got, {OWN, 1'b0});
    bus_stop();
  endtask

  task automatic t_disable();
    bit a, a2; logic [7:0] got;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    host_read(got);
    send_byte(8'h55, a);
    fork
      send_byte(8'h66, a2);
      begin
        wait_stretch();
        enable = 1'b0;
        wait_clk(3);
        check(!scl_drive_low && !sda_drive_low, "R10 disable releases lines",
              {scl_drive_low, sda_drive_low}, 0);
      end
    join
    check(rx_data == 8'h55, "R10 no load while off", rx_data, 8'h55);
    enable = 1'b1;
    host_read(got);
    bus_stop();
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(2);
    enable = 1'b1;
    wait_clk(5);
    t_addr_and_msb();
    t_lsb();
    t_mismatch();
    t_stretch_ack();
    t_after_stop();
    t_rstart();
    t_disable();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule